// File: doc/BRIEF.md
# Programming-Busy Status Read Responder

This block forms the byte a non-volatile memory returns to a host read while its internal programming cycle runs, in one synchronous clock domain. A busy flag from the programming timer selects between two behaviours. When idle, a read returns the stored byte from the array port unchanged. When busy, the read byte carries two completion indicators together, so the host can poll for the end of the write in either of two ways.

The first indicator is an alternating bit on bit 6. It flips on every read access made while busy. The second is a polling bit on bit 7, which returns the inverse of bit 7 of the pending written byte. Bits 5 to 0 return the pending written byte's low bits when the read address matches the last written address. Otherwise they return the array's low bits. A read access is the rising edge of the read strobe. The result is registered on that edge and held until the next access.

Top module: `prog_status_reader`

## Requirements
- R1: After reset, rd_data_o is 0. The alternating-bit state is cleared, so the first busy read afterwards returns 0 on bit 6.
- R2: A read access while busy_i is 0 loads rd_data_o with array_data_i as it is in the access cycle. The new value is visible one clock after the access edge.
- R3: Any two consecutive read accesses within one unbroken busy interval return opposite values on bit 6.
- R4: The first read access after busy_i rises returns 0 on bit 6.
- R5: A read access while busy returns the inverse of last_data_i bit 7 on bit 7, at every address.
- R6: A read access while busy returns last_data_i[5:0] on bits 5..0 when rd_addr_i equals last_addr_i. At any other address it returns array_data_i[5:0].
- R7: rd_data_o holds its value on every cycle without a read access.
- R8: Only a 0-to-1 transition of rd_strobe_i counts as an access. Holding the strobe high makes exactly one access and advances bit 6 only once.
- R9: When busy_i has fallen, the very next read access returns array_data_i in full, with no status bits. This holds even when that access falls in the first cycle of idle.
- R10: A busy read takes bits 7 and 6 only from last_data_i and the alternating state, whatever array_data_i holds. This is the case when a rejected write starts a busy interval and leaves the array untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Internal programming cycle running |
| rd_strobe_i | input | 1 | Read strobe; its rising edge is one access |
| rd_addr_i | input | AW (19) | Address of the read |
| last_addr_i | input | AW (19) | Address of the last written byte |
| last_data_i | input | DW (8) | Value of the last written byte |
| array_data_i | input | DW (8) | True stored data at rd_addr_i |
| rd_data_o | output | DW (8) | Registered read result |

## Verification
On every cycle, the assertions check four things: that the output holds between accesses, the idle pass-through, the polling bit and address-matched low bits of busy reads, and bit 6 of busy reads. For bit 6 they check both the reset-to-zero on the first read of an interval and the inversion between consecutive reads. Some behaviours only the bench scenarios can show. One is that a strobe held high over many cycles advances the alternating bit once. Another is that a busy drop followed by a read in the same cycle returns true data. A third is that a second busy interval restarts the alternation. The last is that array content cannot leak into bits 7 and 6 while busy.

// File: rtl/prs_pkg.sv
package prs_pkg;

  typedef enum logic [1:0] {
    LANE_POLL   = 2'd0,
    LANE_TOGGLE = 2'd1,
    LANE_DATA   = 2'd2
  } lane_kind_e;

  // Role of a byte lane: top bit polls, next bit alternates, rest carry data
  function automatic lane_kind_e lane_of(input int idx, input int width);
    if (idx == width - 1)      return LANE_POLL;
    else if (idx == width - 2) return LANE_TOGGLE;
    else                       return LANE_DATA;
  endfunction

endpackage

// File: rtl/prs_edge.sv
module prs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/prs_toggle.sv
module prs_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic acc_i,
  output logic tgl_o
);
  logic seen_q;
  logic tgl_q;

  // First busy read of an interval reports 0; later ones follow the register
  assign tgl_o = seen_q ? tgl_q : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      tgl_q  <= 1'b0;
    end else if (!busy_i) begin
      seen_q <= 1'b0;
    end else if (acc_i) begin
      seen_q <= 1'b1;
      tgl_q  <= ~tgl_o;
    end
  end
endmodule

// File: rtl/prs_format.sv
module prs_format #(
  parameter int DW = 8,
  parameter int AW = 19
) (
  input  logic          busy_i,
  input  logic          tgl_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [AW-1:0] last_addr_i,
  input  logic [DW-1:0] last_data_i,
  input  logic [DW-1:0] array_data_i,
  output logic [DW-1:0] byte_o
);
  import prs_pkg::*;

  logic addr_hit;
  assign addr_hit = (rd_addr_i == last_addr_i);

  for (genvar i = 0; i < DW; i++) begin : g_lane
    if (lane_of(i, DW) == LANE_POLL) begin : g_poll
      assign byte_o[i] = busy_i ? ~last_data_i[i] : array_data_i[i];
    end else if (lane_of(i, DW) == LANE_TOGGLE) begin : g_tgl
      assign byte_o[i] = busy_i ? tgl_i : array_data_i[i];
    end else begin : g_data
      assign byte_o[i] = (busy_i && addr_hit) ? last_data_i[i] : array_data_i[i];
    end
  end
endmodule

// File: rtl/prog_status_reader.sv
module prog_status_reader #(
  parameter int DW = 8,
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          rd_strobe_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [AW-1:0] last_addr_i,
  input  logic [DW-1:0] last_data_i,
  input  logic [DW-1:0] array_data_i,
  output logic [DW-1:0] rd_data_o
);
  logic          acc_evt;
  logic          tgl_bit;
  logic [DW-1:0] next_byte;

  prs_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (rd_strobe_i),
    .rise_o  (acc_evt)
  );

  prs_toggle u_tgl (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_i (busy_i),
    .acc_i  (acc_evt),
    .tgl_o  (tgl_bit)
  );

  prs_format #(.DW(DW), .AW(AW)) u_fmt (
    .busy_i       (busy_i),
    .tgl_i        (tgl_bit),
    .rd_addr_i    (rd_addr_i),
    .last_addr_i  (last_addr_i),
    .last_data_i  (last_data_i),
    .array_data_i (array_data_i),
    .byte_o       (next_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_data_o <= '0;
    else if (acc_evt) rd_data_o <= next_byte;
  end
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
  parameter int DW = 8,
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_i,
  input logic          acc_evt,
  input logic [AW-1:0] rd_addr_i,
  input logic [AW-1:0] last_addr_i,
  input logic [DW-1:0] last_data_i,
  input logic [DW-1:0] array_data_i,
  input logic [DW-1:0] rd_data_o
);
  // Set once a busy read happened in the current unbroken busy interval
  logic chk_valid;
  always_ff @(posedge clk) begin
    if (!rst_n)                 chk_valid <= 1'b0;
    else if (!busy_i)           chk_valid <= 1'b0;
    else if (acc_evt)           chk_valid <= 1'b1;
  end

  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_evt |=> $stable(rd_data_o));

  a_r2_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && !busy_i) |=> rd_data_o == $past(array_data_i));

  a_r5_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && busy_i) |=> rd_data_o[DW-1] == !$past(last_data_i[DW-1]));

  a_r6_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && busy_i && rd_addr_i == last_addr_i)
      |=> rd_data_o[DW-3:0] == $past(last_data_i[DW-3:0]));

  a_r4_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && busy_i && !chk_valid) |=> !rd_data_o[DW-2]);

  a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && busy_i && chk_valid) |=> rd_data_o[DW-2] != $past(rd_data_o[DW-2]));
endmodule

bind prog_status_reader prs_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_i       (busy_i),
  .acc_evt      (acc_evt),
  .rd_addr_i    (rd_addr_i),
  .last_addr_i  (last_addr_i),
  .last_data_i  (last_data_i),
  .array_data_i (array_data_i),
  .rd_data_o    (rd_data_o)
);

// File: tb/tb_prog_status_reader.sv
`timescale 1ns/1ps
module tb_prog_status_reader;
  localparam int DW = 8;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          busy = 1'b0;
  logic          strobe = 1'b0;
  logic [AW-1:0] raddr = '0;
  logic [AW-1:0] laddr = '0;
  logic [DW-1:0] ldata = '0;
  logic [DW-1:0] adata = '0;
  logic [DW-1:0] rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prog_status_reader #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .rd_strobe_i(strobe),
    .rd_addr_i(raddr), .last_addr_i(laddr), .last_data_i(ldata),
    .array_data_i(adata), .rd_data_o(rdata)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: count busy reads, parity gives the alternating bit
  logic [DW-1:0] m_exp = '0;
  bit m_prev = 0;
  int m_busy_reads = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_exp = '0; m_prev = 0; m_busy_reads = 0;
    end else begin
      if (strobe && !m_prev) begin
        if (busy) begin
          m_exp[7] = ~ldata[7];
          m_exp[6] = (m_busy_reads % 2 == 1);
          m_exp[5:0] = (raddr == laddr) ? ldata[5:0] : adata[5:0];
          m_busy_reads++;
        end else begin
          m_exp = adata;
        end
      end
      if (!busy) m_busy_reads = 0;
      m_prev = strobe;
    end
    #1;
    if (rst_n && !done) check("R7 cycle model compare", rdata, m_exp);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL R1 watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] r);
    @(negedge clk); raddr = a; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0; r = rdata;
  endtask

  logic [DW-1:0] r0, r1, r2, held;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset output", rdata, 8'h00);

    adata = 8'hA5; do_read(19'h00100, r0); check("R2 idle read A5", r0, 8'hA5);
    adata = 8'h3C; do_read(19'h00101, r0); check("R2 idle read 3C", r0, 8'h3C);

    // busy interval: last byte C3 at 0x12, array holds stale 5A
    @(negedge clk); busy = 1'b1; laddr = 19'h00012; ldata = 8'hC3; adata = 8'h5A;
    do_read(19'h00012, r0); check("R4 first busy read bit6 zero, R5 R6", r0, 8'h03);
    do_read(19'h00012, r1); check("R3 second busy read", r1, 8'h43);
    check("R3 consecutive bit6 differ", {7'd0, r1[6] ^ r0[6]}, 8'h01);
    do_read(19'h00040, r2); check("R6 other address low bits from array", r2, 8'h1A);

    // held strobe: one access only
    @(negedge clk); raddr = 19'h00012; strobe = 1'b1;
    repeat (5) @(negedge clk);
    strobe = 1'b0; r0 = rdata; check("R8 held strobe single access", r0, 8'h43);
    do_read(19'h00012, r1); check("R8 next read after held strobe", r1, 8'h03);

    // no access: array changes, output holds
    held = rdata; adata = 8'hFF; repeat (4) @(negedge clk);
    check("R7 hold without access", rdata, held);

    // R10: array unrelated to pending write, status bits unaffected
    adata = 8'hFF; do_read(19'h00012, r0); check("R10 busy read ignores array", r0, 8'h43);
    adata = 8'h00; do_read(19'h00012, r1); check("R10 busy read ignores array 2", r1, 8'h03);

    // busy drop with read in the same cycle
    @(negedge clk); busy = 1'b0; adata = 8'h7E; raddr = 19'h00012; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    check("R9 read right after busy falls", rdata, 8'h7E);

    // second busy interval restarts alternation; last byte bit7 is 0
    @(negedge clk); busy = 1'b1; laddr = 19'h00200; ldata = 8'h15; adata = 8'hC0;
    do_read(19'h00200, r0); check("R4 first read of new interval", r0, 8'h95);
    do_read(19'h00200, r1); check("R5 poll bit inverse of zero", r1, 8'hD5);
    @(negedge clk); busy = 1'b0;

    // reset mid-stream clears alternation
    @(negedge clk); busy = 1'b1; rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check("R1 output cleared by reset", rdata, 8'h00);
    do_read(19'h00200, r0); check("R1 first busy read after reset", r0, 8'h95);
    @(negedge clk); busy = 1'b0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule